// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block runs one SPI master transaction made of 8-bit frames. A start pulse latches a total frame count, a count of frames that take their payload from the transmit stream, and the mode controls: clock polarity, clock phase, bit order and discarding of received data. For each frame the engine fetches a byte from the transmit stream, or uses 0x00 once the transmit count is used up. It then shifts the byte out on MOSI while it samples MISO, and it pushes the received byte to the receive stream unless discarding is selected. The serial clock advances only on tick pulses from an external divider, one tick for each half period.

A two-bit index selects one of four chip-select lines. In automatic mode the selected line is active while a burst runs. In manual mode the selected line follows a level input directly. A polarity input chooses whether chip selects are active high or active low. `busy` works as a start bit that clears itself, and `done` pulses once at the end of every burst, including a burst of length zero.

The transmit side is a valid/ready sink. A byte moves on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while a frame waits for data, and the serial clock holds idle until that byte arrives. The receive side is a push source that never stalls. `rx_valid` is high for exactly one cycle for each received frame. A low `rx_ready` in that cycle drops the byte and pulses `rx_ovf`.

Top module: `spi_burst_engine`

## Requirements
- R1: Each frame is 8 bits. With `lsb_first`=0 bit 7 goes first on the wire. With `lsb_first`=1 bit 0 goes first. Received bytes are assembled in the same order, so a byte sent by the slave in that order is delivered unchanged.
- R2: While idle, `sclk` equals `cpol`. Every frame produces exactly 16 `sclk` transitions. With `cpha`=0, data is sampled on transitions away from the idle level. With `cpha`=1, it is sampled on transitions back to the idle level.
- R3: The first min(tx_len, burst_len) frames carry bytes taken from the transmit stream, in order. All later frames carry 0x00, and no further transmit bytes are accepted.
- R4: With `rx_discard`=0, one received byte per frame is offered on the receive stream, in order. With `rx_discard`=1, `rx_valid` never rises.
- R5: `busy` rises the cycle after `start` is seen while idle. It stays high until the burst ends. `done` is a single-cycle pulse in the last busy cycle. The counts and modes are latched at start, and a `start` while busy is ignored.
- R6: A `burst_len` of 0 raises `done` the cycle after start, with no `sclk` transition.
- R7: While a frame waits on an empty transmit stream, `tx_ready` is high and `sclk` holds its idle level.
- R8: If `rx_ready` is low in a cycle where `rx_valid` is high, that byte is lost and `rx_ovf` pulses in that cycle. With `rx_discard`=1, `rx_ovf` never pulses.
- R9: In automatic mode (`cs_manual`=0), `cs_line[cs_sel]` is at the active level while busy and inactive otherwise. The active level is 1 when `cs_act_high`=1 and 0 when it is 0. All unselected lines are inactive.
- R10: In manual mode, `cs_line[cs_sel]` equals `cs_level` whether or not a burst runs. The other lines are inactive.
- R11: Ticks that arrive while no frame is shifting do not move `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst (taken only when idle) |
| burst_len | input | 24 | Total frames in the burst |
| tx_len | input | 24 | Frames whose payload comes from the transmit stream |
| cpol | input | 1 | Idle clock level |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first | input | 1 | Bit order select |
| rx_discard | input | 1 | Keep received bytes off the receive stream |
| cs_sel | input | 2 | Chip-select index |
| cs_manual | input | 1 | Manual chip-select mode |
| cs_level | input | 1 | Pin level of the selected line in manual mode |
| cs_act_high | input | 1 | Chip-select active level is high |
| sclk_tick | input | 1 | Half-period pulse from the clock divider |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Engine accepts a transmit byte |
| rx_valid | output | 1 | Received byte offered (one cycle) |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Receiver has room |
| rx_ovf | output | 1 | Received byte dropped |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst-complete pulse |

## Verification
`busy` is due one cycle after the edge that takes `start`. `sclk` and `mosi` move one cycle after the edge that processes a tick. `rx_valid` with its byte and `rx_ovf` appear one cycle after the 16th tick of a frame, and `done` appears one cycle after the last frame's `rx_valid` cycle, or one cycle after start for an empty burst. Inputs change one nanosecond after a rising edge and all outputs are observed at the falling edge. A transmit handshake seen at a falling edge is therefore counted only at the following falling edge, after the rising edge that completes it. Totals for edges, bytes, drops and `done` pulses are compared only after a settling gap once `done` has been seen.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int FRAME_BITS      = 8;
  localparam int EDGES_PER_FRAME = 2 * FRAME_BITS;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_t;

  function automatic logic [FRAME_BITS-1:0] flip_bits(input logic [FRAME_BITS-1:0] v);
    logic [FRAME_BITS-1:0] r;
    for (int i = 0; i < FRAME_BITS; i++) r[i] = v[FRAME_BITS-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_burst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_data,
  input  logic                  cpha,
  input  logic                  lsb_first,
  input  logic                  tick,
  input  logic                  miso,
  output logic                  mosi,
  output logic                  phase,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] rx_frame
);
  localparam int EDGE_W = $clog2(EDGES_PER_FRAME);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES_PER_FRAME - 1);

  logic                  active_q;
  logic [EDGE_W-1:0]     edge_q;
  logic [FRAME_BITS-1:0] tx_sr, rx_sr, wire_word;
  logic                  mosi_q, phase_q, done_q;
  logic                  lead_edge, take_sample, push_out;

  // Always shift out of the top bit; bit order is fixed at load time.
  assign wire_word   = lsb_first ? flip_bits(load_data) : load_data;
  assign lead_edge   = ~edge_q[0];
  assign take_sample = cpha ? ~lead_edge : lead_edge;
  assign push_out    = cpha ? lead_edge : (~lead_edge && (edge_q != LAST_EDGE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      edge_q   <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      mosi_q   <= 1'b0;
      phase_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        active_q <= 1'b1;
        edge_q   <= '0;
        phase_q  <= 1'b0;
        if (cpha) begin
          tx_sr <= wire_word;
        end else begin
          mosi_q <= wire_word[FRAME_BITS-1];
          tx_sr  <= {wire_word[FRAME_BITS-2:0], 1'b0};
        end
      end else if (active_q && tick) begin
        phase_q <= ~phase_q;
        edge_q  <= edge_q + 1'b1;
        if (take_sample) rx_sr <= {rx_sr[FRAME_BITS-2:0], miso};
        if (push_out) begin
          mosi_q <= tx_sr[FRAME_BITS-1];
          tx_sr  <= {tx_sr[FRAME_BITS-2:0], 1'b0};
        end
        if (edge_q == LAST_EDGE) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign mosi       = mosi_q;
  assign phase      = phase_q;
  assign frame_done = done_q;
  assign rx_frame   = lsb_first ? flip_bits(rx_sr) : rx_sr;
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      burst_len,
  input  logic [CNT_W-1:0]      tx_len,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic                  lsb_first,
  input  logic                  rx_discard,
  input  logic                  tx_valid,
  input  logic [FRAME_BITS-1:0] tx_data,
  output logic                  tx_ready,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] rx_frame,
  input  logic                  rx_ready,
  output logic                  load,
  output logic [FRAME_BITS-1:0] load_data,
  output logic                  rx_valid,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  rx_ovf,
  output logic                  busy,
  output logic                  done,
  output logic                  cpol_l,
  output logic                  cpha_l,
  output logic                  lsb_l
);
  seq_state_t       state_q;
  logic [CNT_W-1:0] sent_q, burst_q, txl_q, sent_next;
  logic             cpol_q, cpha_q, lsb_q, discard_q;
  logic             from_fifo, in_load, in_shift;

  assign sent_next = sent_q + CNT_W'(1);
  assign from_fifo = sent_q < txl_q;
  assign in_load   = state_q == ST_LOAD;
  assign in_shift  = state_q == ST_SHIFT;

  assign tx_ready  = in_load && from_fifo;
  assign load      = in_load && (!from_fifo || tx_valid);
  assign load_data = from_fifo ? tx_data : '0;

  assign rx_valid  = in_shift && frame_done && !discard_q;
  assign rx_data   = rx_frame;
  assign rx_ovf    = rx_valid && !rx_ready;

  assign busy   = state_q != ST_IDLE;
  assign done   = state_q == ST_FIN;
  assign cpol_l = cpol_q;
  assign cpha_l = cpha_q;
  assign lsb_l  = lsb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sent_q    <= '0;
      burst_q   <= '0;
      txl_q     <= '0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      lsb_q     <= 1'b0;
      discard_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            burst_q   <= burst_len;
            txl_q     <= tx_len;
            cpol_q    <= cpol;
            cpha_q    <= cpha;
            lsb_q     <= lsb_first;
            discard_q <= rx_discard;
            sent_q    <= '0;
            state_q   <= (burst_len == '0) ? ST_FIN : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (load) state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (frame_done) begin
            sent_q  <= sent_next;
            state_q <= (sent_next == burst_q) ? ST_FIN : ST_LOAD;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic [SEL_W-1:0]  cs_sel,
  input  logic              cs_manual,
  input  logic              cs_level,
  input  logic              cs_act_high,
  input  logic              busy,
  output logic [NUM_CS-1:0] cs_line
);
  logic idle_lvl, sel_lvl;

  assign idle_lvl = ~cs_act_high;
  assign sel_lvl  = cs_manual ? cs_level : (busy ? cs_act_high : idle_lvl);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_line[i] = (cs_sel == SEL_W'(i)) ? sel_lvl : idle_lvl;
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NUM_CS = 4,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      burst_len,
  input  logic [CNT_W-1:0]      tx_len,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic                  lsb_first,
  input  logic                  rx_discard,
  input  logic [SEL_W-1:0]      cs_sel,
  input  logic                  cs_manual,
  input  logic                  cs_level,
  input  logic                  cs_act_high,
  input  logic                  sclk_tick,
  input  logic                  tx_valid,
  input  logic [FRAME_BITS-1:0] tx_data,
  output logic                  tx_ready,
  output logic                  rx_valid,
  output logic [FRAME_BITS-1:0] rx_data,
  input  logic                  rx_ready,
  output logic                  rx_ovf,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso,
  output logic [NUM_CS-1:0]     cs_line,
  output logic                  busy,
  output logic                  done
);
  logic                  load, frame_done, phase;
  logic [FRAME_BITS-1:0] load_data, rx_frame;
  logic                  cpol_l, cpha_l, lsb_l;

  spi_burst_seq #(.CNT_W(CNT_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .burst_len  (burst_len),
    .tx_len     (tx_len),
    .cpol       (cpol),
    .cpha       (cpha),
    .lsb_first  (lsb_first),
    .rx_discard (rx_discard),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .frame_done (frame_done),
    .rx_frame   (rx_frame),
    .rx_ready   (rx_ready),
    .load       (load),
    .load_data  (load_data),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ovf     (rx_ovf),
    .busy       (busy),
    .done       (done),
    .cpol_l     (cpol_l),
    .cpha_l     (cpha_l),
    .lsb_l      (lsb_l)
  );

  spi_frame_shifter shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_data  (load_data),
    .cpha       (cpha_l),
    .lsb_first  (lsb_l),
    .tick       (sclk_tick),
    .miso       (miso),
    .mosi       (mosi),
    .phase      (phase),
    .frame_done (frame_done),
    .rx_frame   (rx_frame)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) cs_i (
    .cs_sel      (cs_sel),
    .cs_manual   (cs_manual),
    .cs_level    (cs_level),
    .cs_act_high (cs_act_high),
    .busy        (busy),
    .cs_line     (cs_line)
  );

  // Idle level follows the live input; during a burst the latched copy holds it.
  assign sclk = (busy ? cpol_l : cpol) ^ phase;
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk #(
  parameter int CNT_W  = 24,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  burst_len,
  input logic              cpol,
  input logic              cs_manual,
  input logic              cs_act_high,
  input logic [NUM_CS-1:0] cs_line,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              sclk,
  input logic              busy,
  input logic              done
);
  // R2
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R5
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R6
  zero_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && burst_len == '0) |=> done);

  // R3
  tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |-> (busy && !done));

  // R4
  rx_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (busy && !done));

  // R9
  auto_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_manual) |-> $countones(cs_line ^ {NUM_CS{~cs_act_high}}) == 1);
endmodule

bind spi_burst_engine spi_burst_engine_chk #(.CNT_W(CNT_W), .NUM_CS(NUM_CS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .burst_len   (burst_len),
  .cpol        (cpol),
  .cs_manual   (cs_manual),
  .cs_act_high (cs_act_high),
  .cs_line     (cs_line),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .rx_valid    (rx_valid),
  .sclk        (sclk),
  .busy        (busy),
  .done        (done)
);

// File: tb/spi_burst_engine_tb_top.sv
`timescale 1ns/1ps
module spi_burst_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0, rx_discard = 1'b0;
  logic [1:0] cs_sel = '0;
  logic cs_manual = 1'b0, cs_level = 1'b0, cs_act_high = 1'b0;
  logic sclk_tick = 1'b0, tx_valid = 1'b0, rx_ready = 1'b1, miso = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_ovf, sclk, mosi, busy, done;
  logic [7:0] rx_data;
  logic [3:0] cs_line;

  always #2 clk = ~clk;

  spi_burst_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len), .tx_len(tx_len),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .rx_discard(rx_discard),
    .cs_sel(cs_sel), .cs_manual(cs_manual), .cs_level(cs_level), .cs_act_high(cs_act_high),
    .sclk_tick(sclk_tick), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .rx_ovf(rx_ovf),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_line(cs_line), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0, cycles = 0;
  int cur_id = 0, tx_idx = 0, tx_avail = 0, mosi_cnt = 0, rx_cnt = 0, ovf_cnt = 0;
  int done_cnt = 0, edge_cnt = 0, slv_k = 0, slv_byte = 0;
  bit hs_pend = 0, tx_hold = 0, cs_snapped = 0, prev_sclk = 0;
  logic [7:0] cap = '0, pbyte;
  logic [3:0] cs_snap = '0;
  logic [7:0] mosi_bytes [0:7];
  logic [7:0] rx_got [0:7];

  function automatic logic [7:0] txbyte(int id, int i);
    return 8'((id * 29 + i * 83 + 17) & 255);
  endfunction
  function automatic logic [7:0] slvbyte(int id, int i);
    return 8'((id * 53 + i * 101 + 200) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor, slave model, tick source and transmit feed; acts at falling edges.
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (hs_pend) tx_idx++;
      tx_valid = !tx_hold && (tx_idx < tx_avail);
      tx_data  = txbyte(cur_id, tx_idx);
      hs_pend  = tx_valid && tx_ready;
      if (rx_valid && rx_ready) begin
        if (rx_cnt < 8) rx_got[rx_cnt] = rx_data;
        rx_cnt++;
      end
      if (rx_ovf) ovf_cnt++;
      if (done) done_cnt++;
      if (sclk != prev_sclk) begin
        edge_cnt++;
        if (!cs_snapped) begin cs_snap = cs_line; cs_snapped = 1; end
        if (cpha ? (sclk == cpol) : (sclk != cpol)) begin
          if (lsb_first) cap[slv_k] = mosi; else cap[7 - slv_k] = mosi;
          slv_k++;
          if (slv_k == 8) begin
            if (mosi_cnt < 8) mosi_bytes[mosi_cnt] = cap;
            mosi_cnt++;
            slv_k = 0;
            slv_byte++;
          end
        end
      end
      prev_sclk = sclk;
      pbyte = slvbyte(cur_id, slv_byte);
      miso = lsb_first ? pbyte[slv_k] : pbyte[7 - slv_k];
      sclk_tick = ~sclk_tick;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  task automatic tick_cycles(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic run_burst(input int b, input int t, input bit cp, input bit ch, input bit lf,
                           input bit dc, input bit rdy, input bit man, input bit lvl,
                           input int hold, input bit rs);
    int waited, exp_tx, exp_ovf, sel;
    bit act;
    logic [3:0] exp_cs;
    @(posedge clk); #1;
    cur_id++;
    sel = cur_id % 4;
    act = ((cur_id / 4) % 2) != 0;
    cpol = cp; cpha = ch; lsb_first = lf; rx_discard = dc; rx_ready = rdy;
    cs_sel = 2'(sel); cs_manual = man; cs_level = lvl; cs_act_high = act;
    burst_len = 24'(b); tx_len = 24'(t);
    tx_idx = 0; hs_pend = 0; tx_avail = t + 4; tx_hold = (hold > 0);
    mosi_cnt = 0; rx_cnt = 0; ovf_cnt = 0; done_cnt = 0; edge_cnt = 0;
    slv_k = 0; slv_byte = 0; cs_snapped = 0; prev_sclk = cp;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (hold > 0) begin
      tick_cycles(hold);
      check(edge_cnt == 0, "R7 clock held while tx empty", edge_cnt, 0);
      check(tx_ready == 1'b1, "R7 tx_ready while waiting", int'(tx_ready), 1);
      check(sclk == cp, "R7 sclk idle level while waiting", int'(sclk), int'(cp));
      tx_hold = 0;
    end
    if (rs) begin
      tick_cycles(10);
      burst_len = 24'(1);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 3000) begin
      @(posedge clk); #1;
      waited++;
    end
    tick_cycles(4);
    check(done_cnt == 1, "R5 one done pulse", done_cnt, 1);
    check(busy == 1'b0, "R5 busy cleared", int'(busy), 0);
    if (b == 0) check(waited <= 1, "R6 empty burst completes at once", waited, 1);
    check(edge_cnt == 16 * b, "R2 sixteen sclk transitions per frame", edge_cnt, 16 * b);
    check(sclk == cp, "R2 sclk returns to idle", int'(sclk), int'(cp));
    exp_tx = (t < b) ? t : b;
    check(tx_idx == exp_tx, "R3 transmit bytes consumed", tx_idx, exp_tx);
    check(mosi_cnt == b, "R1 frames seen on mosi", mosi_cnt, b);
    for (int i = 0; i < b && i < 8; i++)
      check(mosi_bytes[i] == ((i < t) ? txbyte(cur_id, i) : 8'h00), "R3 R1 mosi byte",
            int'(mosi_bytes[i]), int'((i < t) ? txbyte(cur_id, i) : 8'h00));
    if (rdy) begin
      check(rx_cnt == (dc ? 0 : b), "R4 received byte count", rx_cnt, dc ? 0 : b);
      for (int i = 0; i < rx_cnt && i < 8; i++)
        check(rx_got[i] == slvbyte(cur_id, i), "R1 R4 received byte", int'(rx_got[i]),
              int'(slvbyte(cur_id, i)));
    end
    exp_ovf = (!rdy && !dc) ? b : 0;
    check(ovf_cnt == exp_ovf, "R8 overflow pulses", ovf_cnt, exp_ovf);
    if (b > 0) begin
      for (int i = 0; i < 4; i++)
        exp_cs[i] = (i == sel) ? (man ? lvl : act) : ~act;
      check(cs_snap == exp_cs, "R9 R10 chip selects during burst", int'(cs_snap), int'(exp_cs));
    end
  endtask

  initial begin
    int e0;
    tick_cycles(5);
    // Reset state, with chip selects active low
    check(busy == 0 && done == 0, "R5 reset idle", int'(busy), 0);
    check(sclk == 1'b0, "R2 reset sclk at cpol", int'(sclk), 0);
    check(cs_line == 4'hF, "R9 reset chip selects inactive", int'(cs_line), 15);
    check(tx_ready == 0 && rx_valid == 0, "R4 reset streams quiet", int'(tx_ready), 0);
    rst_n = 1'b1;
    tick_cycles(3);

    // Near-exhaustive sweep over modes, burst lengths and transmit counts
    for (int m = 0; m < 16; m++)
      for (int b = 0; b < 4; b++)
        for (int t = 0; t <= b + 1; t++)
          run_burst(b, t, m[0], m[1], m[2], m[3], 1'b1, 1'b0, 1'b0, 0, 1'b0);

    // R8 receive side full
    run_burst(2, 2, 1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 0);
    run_burst(2, 2, 1'b1, 1, 0, 1, 1'b0, 0, 0, 0, 0);
    // R7 stall on empty transmit stream, both phases
    run_burst(2, 2, 0, 0, 0, 0, 1, 0, 0, 40, 0);
    run_burst(2, 1, 1, 1, 1, 0, 1, 0, 0, 40, 0);
    // R5 second start while busy ignored; counts latched
    run_burst(3, 3, 0, 1, 0, 0, 1, 0, 0, 0, 1);
    // R10 manual chip select during a burst
    run_burst(1, 1, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    run_burst(1, 1, 1, 0, 0, 0, 1, 1, 0, 0, 0);

    // R10 manual chip select while idle
    @(posedge clk); #1;
    cs_manual = 1; cs_sel = 2'd1; cs_act_high = 0; cs_level = 0;
    @(negedge clk);
    check(cs_line == 4'b1101, "R10 manual level low", int'(cs_line), 13);
    @(posedge clk); #1;
    cs_level = 1; cs_act_high = 1;
    @(negedge clk);
    check(cs_line == 4'b0010, "R10 manual level high", int'(cs_line), 2);
    @(posedge clk); #1;
    cs_manual = 0; cs_sel = 2'd3;
    @(negedge clk);
    check(cs_line == 4'b0000, "R9 idle auto mode inactive", int'(cs_line), 0);

    // R11 ticks while idle leave sclk alone
    e0 = edge_cnt;
    tick_cycles(30);
    check(edge_cnt == e0, "R11 idle ticks ignored", edge_cnt, e0);

    finish_run();
  end
endmodule